// File: doc/BRIEF.md
# Frame-Locked Pause Interrupt Generator

This block turns a raw pause pushbutton into an active-low non-maskable interrupt level for the processor. The button contact bounces many times on each press, and the interrupt must never change in the middle of the picture. So the block does not filter the button continuously. It looks at the button exactly once per video frame and copies that sample to the interrupt output. The interrupt therefore follows the button, but with at most one change per frame.

The sample point is the start of the final scanline of the frame. It is recognised from the line number and horizontal position that a raster timing generator supplies. The block counts horizontal positions in master clocks from pixel 0. The start of the last line is the horizontal sync rising edge, 611 master clocks into the line before it. The number of lines per frame is a parameter, so one design serves both the 262-line and the 313-line raster. Before it is used, the button passes through a two-flop synchronizer. After reset the interrupt stays released until the first sample point has passed.

Top module: `pause_nmi_sync`

## Requirements
- R1: After reset, `nmi_n` is 1 and stays 1 until the first update point.
- R2: The button passes through two synchronizer flops. A level applied for fewer than two clock edges before the update edge is not seen at that update.
- R3: The update point is the cycle in which `line_num` equals LINES_PER_FRAME-2 and `hpos` equals UPD_HPOS (611 by default). In that case `nmi_n` takes the inverse of the synchronized button (1 = pressed) on the clock edge that ends the cycle.
- R4: A press that happens earlier in the frame leaves `nmi_n` at 1 until the update point. This holds for the correct horizontal position on any other line, and for any other position on the pre-final line.
- R5: While the button stays pressed, `nmi_n` stays 0 through later frames and their update points.
- R6: After release, `nmi_n` stays 0 until the next update point, where it returns to 1.
- R7: Any number of button transitions between update points has no effect. Only the level present at the update point counts.
- R8: With LINES_PER_FRAME = 313, the update happens on line 311 and not on line 260.
- R9: If the update position is held for several consecutive cycles, only its first cycle samples the button.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 1 | Asynchronous pause button level, 1 = pressed |
| line_num | input | LINE_W | Current scanline number from the raster generator |
| hpos | input | HPOS_W | Master-clock position within the line, 0 = pixel 0 |
| nmi_n | output | 1 | Active-low NMI request level |

## Verification
A wrong sample-point decode shows up as a change of `nmi_n` on some line or position other than the update point. A fault in the synchronizer or in the edge detection shows up as a level at the update point that disagrees with the button level from two edges earlier. A held or stuck output register appears at the very next update point, one frame later at most. The bench therefore drives the raster position directly, jumps to the cycles around the update point, and checks `nmi_n` one edge after each candidate position.

// File: rtl/pause_nmi_sync.sv
module pause_nmi_sync #(
  parameter int LINES_PER_FRAME = 262,
  parameter int LINE_W          = 9,
  parameter int HPOS_W          = 10,
  parameter int UPD_HPOS        = 611
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_raw,
  input  logic [LINE_W-1:0] line_num,
  input  logic [HPOS_W-1:0] hpos,
  output logic              nmi_n
);
  localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES_PER_FRAME - 2);
  localparam logic [HPOS_W-1:0] EDGE_POS = HPOS_W'(UPD_HPOS);

  logic btn_s1, btn_s2, at_edge, at_edge_q, take;

  assign at_edge = (line_num == PRE_LINE) && (hpos == EDGE_POS);
  assign take    = at_edge && !at_edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_s1    <= 1'b0;
      btn_s2    <= 1'b0;
      at_edge_q <= 1'b0;
      nmi_n     <= 1'b1;
    end else begin
      btn_s1    <= btn_raw;
      btn_s2    <= btn_s1;
      at_edge_q <= at_edge;
      if (take) nmi_n <= !btn_s2;
    end
  end
endmodule

module pause_nmi_sync_chk #(
  parameter int LINES_PER_FRAME = 262,
  parameter int LINE_W          = 9,
  parameter int HPOS_W          = 10,
  parameter int UPD_HPOS        = 611
) (
  input logic              clk,
  input logic              rst_n,
  input logic              btn_raw,
  input logic [LINE_W-1:0] line_num,
  input logic [HPOS_W-1:0] hpos,
  input logic              nmi_n
);
  logic       hit;
  logic       seen;
  logic [1:0] age;

  assign hit = (int'(line_num) == LINES_PER_FRAME - 2) && (int'(hpos) == UPD_HPOS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      age  <= 2'd0;
    end else begin
      if (hit) seen <= 1'b1;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  // R1
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> nmi_n);

  // R4
  p_change_only_at_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$stable(nmi_n)) |-> $past(hit));

  // R4
  p_off_line_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(line_num) != LINES_PER_FRAME - 2) |=> $stable(nmi_n));

  // R3, R2
  p_sample_two_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && hit && !$past(hit)) |=> (nmi_n == !$past(btn_raw, 3)));
endmodule

bind pause_nmi_sync pause_nmi_sync_chk #(
  .LINES_PER_FRAME(LINES_PER_FRAME), .LINE_W(LINE_W),
  .HPOS_W(HPOS_W), .UPD_HPOS(UPD_HPOS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw),
  .line_num(line_num), .hpos(hpos), .nmi_n(nmi_n)
);

// File: tb/sim_pause_nmi_sync.sv
`timescale 1ns/1ps
module sim_pause_nmi_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn = 1'b0;
  logic [8:0] line = 9'd0;
  logic [9:0] hpos = 10'd0;
  logic       nmi0, nmi1;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pause_nmi_sync u0 (.clk(clk), .rst_n(rst_n), .btn_raw(btn),
                     .line_num(line), .hpos(hpos), .nmi_n(nmi0));

  pause_nmi_sync #(.LINES_PER_FRAME(313)) u1 (.clk(clk), .rst_n(rst_n), .btn_raw(btn),
                     .line_num(line), .hpos(hpos), .nmi_n(nmi1));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int l, input int h);
    line = 9'(l);
    hpos = 10'(h);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) step(10, 0);
  endtask

  task automatic t_reset();
    check("R1 reset u0", nmi0, 1'b1);
    check("R1 reset u1", nmi1, 1'b1);
    btn = 1'b1;
    settle();
    step(100, 5);
    check("R1 idle before first update", nmi0, 1'b1);
    btn = 1'b0;
    settle();
  endtask

  task automatic t_late_press();
    step(260, 600);
    btn = 1'b1;
    step(260, 611);
    check("R2 one-edge-old press unseen", nmi0, 1'b1);
    settle();
  endtask

  task automatic t_press();
    step(100, 611);
    check("R4 right hpos wrong line", nmi0, 1'b1);
    step(260, 610);
    check("R4 line 260 before edge", nmi0, 1'b1);
    step(260, 611);
    check("R3 asserted at update point", nmi0, 1'b0);
    check("R8 313-line instance ignores line 260", nmi1, 1'b1);
    step(261, 0);
    step(311, 611);
    check("R8 313-line instance updates at line 311", nmi1, 1'b0);
  endtask

  task automatic t_hold();
    step(0, 0);
    step(150, 300);
    check("R5 held mid-frame", nmi0, 1'b0);
    step(260, 611);
    check("R5 held through next update", nmi0, 1'b0);
  endtask

  task automatic t_release();
    step(50, 0);
    btn = 1'b0;
    settle();
    step(200, 611);
    check("R6 release not yet seen", nmi0, 1'b1 ^ 1'b1);
    step(260, 611);
    check("R6 negated at next update", nmi0, 1'b1);
  endtask

  task automatic t_bounce();
    for (int i = 0; i < 50; i++) begin
      btn = ~btn;
      step(20 + i, i * 7);
    end
    btn = 1'b0;
    settle();
    step(260, 611);
    check("R7 bounce ending released", nmi0, 1'b1);
    for (int i = 0; i < 51; i++) begin
      btn = ~btn;
      step(30 + i, i * 3);
    end
    btn = 1'b1;
    settle();
    check("R7 bounce between updates no effect", nmi0, 1'b1);
    step(260, 611);
    check("R7 bounce ending pressed", nmi0, 1'b0);
  endtask

  task automatic t_held_pos();
    step(0, 0);
    btn = 1'b0;
    settle();
    step(260, 611);
    check("R9 first cycle samples", nmi0, 1'b1);
    btn = 1'b1;
    for (int i = 0; i < 4; i++) step(260, 611);
    check("R9 held position no resample", nmi0, 1'b1);
    step(261, 0);
    step(260, 611);
    check("R9 new occurrence samples", nmi0, 1'b0);
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_late_press();
    t_press();
    t_hold();
    t_release();
    t_bounce();
    t_held_pos();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule